// File: doc/BRIEF.md
# Output Voltage Transition Sequencer

This block drives the reference code of a step-down regulator's DAC when a select input moves the output between two setpoints. A rise of the select line starts an upward move. The move is either a staircase, with one LSB per programmed interval, or a single load of the high code. A fall of the select line loads the low code at once. While the output falls, the block holds the power stage in pulse-skipping operation with reverse current blocked, until the feedback path reports that the output has settled.

A power-good flag covers each transition. After a staircase it stays low for a fixed delay that starts at the last step. After a single-step move it stays low until the settled indication arrives, and then for a second fixed delay. While an upward move is in progress, light-load operation is held off, whatever the mode request says. When no transition is pending, the pulse-skipping enable follows the mode request. If the select line reverses partway through a move, the block starts the new move from the code the DAC holds at that moment.

Top module: `vout_seq`

## Requirements
- R1: While reset is low, the DAC code equals the low setpoint, power-good is 0, the inhibit, block and frequency flags are 0, and the pulse-skipping enable equals the mode request. Power-good rises POK_STEP_CYC clock edges after reset is released, provided the select input stays 0.
- R2: With a slew code c from 0 to 6 (3'b000 to 3'b110), an upward move changes the DAC code by one LSB toward the high setpoint every BASE_IVL<<c clock edges. The first step comes BASE_IVL<<c edges after the edge that samples the select rise.
- R3: With slew code 3'b111, the DAC code equals the high setpoint one clock edge after the select rise is sampled.
- R4: After a staircase, power-good is 0 for POK_STEP_CYC-1 edges after the edge of the final step, and it is 1 after the POK_STEP_CYC-th edge.
- R5: After a single-step move, power-good rises exactly POK_SETTLE_CYC edges after the first edge that samples the settled input high.
- R6: From the first edge of an upward move until power-good rises, the pulse-skipping enable is 0 and the PFM-inhibit flag is 1, whatever the mode request.
- R7: One edge after a select fall is sampled, the DAC code equals the low setpoint. From then until the settled input is sampled high, power-good is 0 and the pulse-skipping enable, reverse-block flag and minimum-frequency-inhibit flag are all 1, whatever the mode request. On the edge that samples settled high, power-good becomes 1, both flags clear, and the enable follows the mode request again.
- R8: A select change during a transition starts the new move from the DAC code held at that moment: a fall loads the low setpoint, and a rise ramps from the current code. Power-good stays 0 until the new move completes.
- R9: With power-good at 1, the pulse-skipping enable follows the mode request combinationally, and the three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Setpoint select: 1 for high, 0 for low |
| slew_i | input | 3 | Ramp rate code; 3'b111 selects a single step |
| low_code_i | input | CODE_W | Low setpoint DAC code |
| high_code_i | input | CODE_W | High setpoint DAC code |
| mode_pfm_i | input | 1 | Mode request: 1 allows pulse skipping at light load |
| settled_i | input | 1 | Output settled at the new setpoint, from the feedback path |
| dac_code_o | output | CODE_W | Reference DAC code |
| pgood_o | output | 1 | Power-good status |
| pfm_en_o | output | 1 | Pulse-skipping enable |
| pfm_inhibit_o | output | 1 | Pulse skipping held off during an upward move |
| rev_block_o | output | 1 | Inductor reverse current blocked |
| minfreq_inhibit_o | output | 1 | Minimum-frequency control held off |

## Verification
Two functions can act on the same edge. A select reversal can land on the very edge where a staircase step timer expires, and it always contends with the power-good delay that would otherwise run. The bench drops the select line one cycle after a step in a slow ramp, and it raises the line again while the downward move is still waiting for settle. It then checks that the DAC code jumps to the low setpoint instead of stepping, that the next ramp starts from that code, and that power-good does not rise between the two moves.

// File: rtl/vout_seq_pkg.sv
package vout_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RAMP = 3'd1,
      ST_JUMP = 3'd2,
      ST_POK  = 3'd3,
      ST_DOWN = 3'd4
   } seq_state_e;

   localparam logic [2:0] SLEW_SINGLE = 3'b111;
   localparam int         SLEW_CODES  = 8;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/vout_seq_tmr.sv
module vout_seq_tmr #(
   parameter int TMR_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] val_i,
   input  logic             en_i,
   output logic             zero_o
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= TMR_W'(RST_VAL);
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (en_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - TMR_W'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vout_seq_ctrl.sv
module vout_seq_ctrl
   import vout_seq_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic [2:0]        slew_i,
   input  logic [CODE_W-1:0] low_code_i,
   input  logic [CODE_W-1:0] high_code_i,
   input  logic              settled_i,
   input  logic              ivl_zero_i,
   input  logic              pok_zero_i,
   output seq_state_e        st_o,
   output logic              up_o,
   output logic              sel_seen_o,
   output logic [CODE_W-1:0] dac_o,
   output logic              ivl_load_o,
   output logic              ivl_en_o,
   output logic [2:0]        ivl_sel_o,
   output logic              pok_load_o,
   output logic              pok_en_o,
   output logic              pok_settle_o
);

   seq_state_e        st_q, st_d;
   logic [CODE_W-1:0] dac_q, dac_d, step_code;
   logic              up_q, up_d;
   logic              sel_q;
   logic [2:0]        slew_q;
   logic              rise, fall, start;

   assign rise = sel_i & ~sel_q;
   assign fall = ~sel_i & sel_q;

   assign step_code = (dac_q < high_code_i) ? dac_q + CODE_W'(1)
                                            : dac_q - CODE_W'(1);

   always_comb begin
      st_d         = st_q;
      dac_d        = dac_q;
      up_d         = up_q;
      start        = 1'b0;
      ivl_load_o   = 1'b0;
      ivl_en_o     = 1'b0;
      pok_load_o   = 1'b0;
      pok_en_o     = 1'b0;
      pok_settle_o = 1'b0;
      if (fall) begin
         st_d  = ST_DOWN;
         dac_d = low_code_i;
         up_d  = 1'b0;
      end else if (rise) begin
         up_d  = 1'b1;
         start = 1'b1;
         if (slew_i == SLEW_SINGLE) begin
            st_d  = ST_JUMP;
            dac_d = high_code_i;
         end else if (dac_q == high_code_i) begin
            st_d       = ST_POK;
            pok_load_o = 1'b1;
         end else begin
            st_d       = ST_RAMP;
            ivl_load_o = 1'b1;
         end
      end else begin
         unique case (st_q)
            ST_RAMP: begin
               if (ivl_zero_i) begin
                  dac_d = step_code;
                  if (step_code == high_code_i) begin
                     st_d       = ST_POK;
                     pok_load_o = 1'b1;
                  end else begin
                     ivl_load_o = 1'b1;
                  end
               end else begin
                  ivl_en_o = 1'b1;
               end
            end
            ST_JUMP: begin
               if (settled_i) begin
                  st_d         = ST_POK;
                  pok_load_o   = 1'b1;
                  pok_settle_o = 1'b1;
               end
            end
            ST_POK: begin
               if (pok_zero_i) begin
                  st_d = ST_IDLE;
               end else begin
                  pok_en_o = 1'b1;
               end
            end
            ST_DOWN: begin
               if (settled_i) begin
                  st_d = ST_IDLE;
               end
            end
            default: begin
               st_d = st_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_POK;
         dac_q  <= low_code_i;
         up_q   <= 1'b0;
         sel_q  <= 1'b0;
         slew_q <= '0;
      end else begin
         st_q  <= st_d;
         dac_q <= dac_d;
         up_q  <= up_d;
         sel_q <= sel_i;
         if (start) begin
            slew_q <= slew_i;
         end
      end
   end

   assign ivl_sel_o  = start ? slew_i : slew_q;
   assign st_o       = st_q;
   assign up_o       = up_q;
   assign sel_seen_o = sel_q;
   assign dac_o      = dac_q;

   // R2
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RAMP && !fall) |=>
         (dac_q == $past(dac_q)) ||
         (dac_q == $past(dac_q) + CODE_W'(1)) ||
         (dac_q == $past(dac_q) - CODE_W'(1)));

   // R3
   jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && slew_i == SLEW_SINGLE) |=> (dac_q == $past(high_code_i)));

   // R7
   down_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (dac_q == $past(low_code_i)) && (st_q == ST_DOWN));

endmodule

// File: rtl/vout_seq_modes.sv
module vout_seq_modes
   import vout_seq_pkg::*;
(
   input  seq_state_e st_i,
   input  logic       up_i,
   input  logic       mode_pfm_i,
   output logic       pgood_o,
   output logic       pfm_en_o,
   output logic       pfm_inhibit_o,
   output logic       rev_block_o,
   output logic       minfreq_inhibit_o
);

   always_comb begin
      pgood_o           = (st_i == ST_IDLE);
      pfm_en_o          = mode_pfm_i;
      pfm_inhibit_o     = 1'b0;
      rev_block_o       = 1'b0;
      minfreq_inhibit_o = 1'b0;
      unique case (st_i)
         ST_DOWN: begin
            pfm_en_o          = 1'b1;
            rev_block_o       = 1'b1;
            minfreq_inhibit_o = 1'b1;
         end
         ST_RAMP, ST_JUMP: begin
            pfm_en_o      = 1'b0;
            pfm_inhibit_o = 1'b1;
         end
         ST_POK: begin
            if (up_i) begin
               pfm_en_o      = 1'b0;
               pfm_inhibit_o = 1'b1;
            end
         end
         default: begin
            pfm_en_o = mode_pfm_i;
         end
      endcase
   end

endmodule

// File: rtl/vout_seq.sv
module vout_seq
   import vout_seq_pkg::*;
#(
   parameter int CODE_W         = 8,
   parameter int BASE_IVL       = 4,
   parameter int POK_STEP_CYC   = 188,
   parameter int POK_SETTLE_CYC = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic [2:0]        slew_i,
   input  logic [CODE_W-1:0] low_code_i,
   input  logic [CODE_W-1:0] high_code_i,
   input  logic              mode_pfm_i,
   input  logic              settled_i,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              pgood_o,
   output logic              pfm_en_o,
   output logic              pfm_inhibit_o,
   output logic              rev_block_o,
   output logic              minfreq_inhibit_o
);

   localparam int MAX_IVL = BASE_IVL << (SLEW_CODES - 2);
   localparam int MAX_CNT = max3(MAX_IVL, POK_STEP_CYC, POK_SETTLE_CYC);
   localparam int TMR_W   = $clog2(MAX_CNT + 1);

   if (CODE_W < 2) begin : g_bad_code_w
      $error("vout_seq: CODE_W must be at least 2");
   end
   if (BASE_IVL < 1) begin : g_bad_ivl
      $error("vout_seq: BASE_IVL must be at least 1");
   end
   if (POK_STEP_CYC < 1 || POK_SETTLE_CYC < 1) begin : g_bad_pok
      $error("vout_seq: power-good delays must be at least 1");
   end

   logic [TMR_W-1:0] ivl_tab [SLEW_CODES];

   for (genvar g = 0; g < SLEW_CODES; g++) begin : g_ivl
      if (g < SLEW_CODES - 1) begin : g_ramp
         assign ivl_tab[g] = TMR_W'((BASE_IVL << g) - 1);
      end else begin : g_single
         assign ivl_tab[g] = '0;
      end
   end

   seq_state_e       st;
   logic             up_seen, sel_seen;
   logic             ivl_load, ivl_en, ivl_zero;
   logic [2:0]       ivl_sel;
   logic             pok_load, pok_en, pok_zero, pok_settle;
   logic [TMR_W-1:0] ivl_val, pok_val;

   assign ivl_val = ivl_tab[ivl_sel];
   assign pok_val = pok_settle ? TMR_W'(POK_SETTLE_CYC - 1)
                               : TMR_W'(POK_STEP_CYC - 1);

   vout_seq_ctrl #(
      .CODE_W (CODE_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (sel_i),
      .slew_i       (slew_i),
      .low_code_i   (low_code_i),
      .high_code_i  (high_code_i),
      .settled_i    (settled_i),
      .ivl_zero_i   (ivl_zero),
      .pok_zero_i   (pok_zero),
      .st_o         (st),
      .up_o         (up_seen),
      .sel_seen_o   (sel_seen),
      .dac_o        (dac_code_o),
      .ivl_load_o   (ivl_load),
      .ivl_en_o     (ivl_en),
      .ivl_sel_o    (ivl_sel),
      .pok_load_o   (pok_load),
      .pok_en_o     (pok_en),
      .pok_settle_o (pok_settle)
   );

   vout_seq_tmr #(
      .TMR_W   (TMR_W),
      .RST_VAL (0)
   ) u_ivl_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ivl_load),
      .val_i  (ivl_val),
      .en_i   (ivl_en),
      .zero_o (ivl_zero)
   );

   vout_seq_tmr #(
      .TMR_W   (TMR_W),
      .RST_VAL (POK_STEP_CYC - 1)
   ) u_pok_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pok_load),
      .val_i  (pok_val),
      .en_i   (pok_en),
      .zero_o (pok_zero)
   );

   vout_seq_modes u_modes (
      .st_i              (st),
      .up_i              (up_seen),
      .mode_pfm_i        (mode_pfm_i),
      .pgood_o           (pgood_o),
      .pfm_en_o          (pfm_en_o),
      .pfm_inhibit_o     (pfm_inhibit_o),
      .rev_block_o       (rev_block_o),
      .minfreq_inhibit_o (minfreq_inhibit_o)
   );

   // R4 R5
   pgood_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood_o) |-> ($past(pok_zero) || $past(settled_i)));

   // R8
   retarget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgood_o && (sel_i != sel_seen)) |=> !pgood_o);

   // R6
   pfm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_seen && !pgood_o) |-> !pfm_en_o);

endmodule

// File: tb/vout_seq_bench.sv
module vout_seq_bench;

   localparam int CW    = 8;
   localparam int BASE  = 2;
   localparam int DSTEP = 6;
   localparam int DSET  = 4;
   localparam logic [CW-1:0] LOW  = 8'h10;
   localparam logic [CW-1:0] HIGH = 8'h14;
   localparam int NSTEP = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sel, mode, settled;
   logic [2:0]    slew;
   logic [CW-1:0] dac;
   logic          pg, pen, inh, rev, mf;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int            at;
      logic [CW-1:0] dac;
      logic          pg, pen, inh, rev, mf;
      string         req;
   } exp_t;

   exp_t q[$];
   exp_t it;

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   vout_seq #(
      .CODE_W         (CW),
      .BASE_IVL       (BASE),
      .POK_STEP_CYC   (DSTEP),
      .POK_SETTLE_CYC (DSET)
   ) u_vout_seq (
      .clk               (clk),
      .rst_n             (rst_n),
      .sel_i             (sel),
      .slew_i            (slew),
      .low_code_i        (LOW),
      .high_code_i       (HIGH),
      .mode_pfm_i        (mode),
      .settled_i         (settled),
      .dac_code_o        (dac),
      .pgood_o           (pg),
      .pfm_en_o          (pen),
      .pfm_inhibit_o     (inh),
      .rev_block_o       (rev),
      .minfreq_inhibit_o (mf)
   );

   task automatic push(input int at, input logic [CW-1:0] d, input logic g,
                       input logic e, input logic i, input logic r,
                       input logic m, input string req);
      exp_t x;
      x.at = at; x.dac = d; x.pg = g; x.pen = e;
      x.inh = i; x.rev = r; x.mf = m; x.req = req;
      q.push_back(x);
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      #2;
      while (q.size() > 0 && q[0].at <= cyc) begin
         it = q.pop_front();
         checks++;
         if (it.at < cyc || dac !== it.dac || pg !== it.pg || pen !== it.pen ||
             inh !== it.inh || rev !== it.rev || mf !== it.mf) begin
            errors++;
            $display("FAIL %s cyc %0d actual dac=%h pg=%b pen=%b inh=%b rev=%b mf=%b expected dac=%h pg=%b pen=%b inh=%b rev=%b mf=%b",
                     it.req, cyc, dac, pg, pen, inh, rev, mf,
                     it.dac, it.pg, it.pen, it.inh, it.rev, it.mf);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int c0, e0, e1, e2, et;
      rst_n = 1'b0; sel = 1'b0; slew = 3'd0; mode = 1'b1; settled = 1'b0;
      repeat (3) @(negedge clk);
      // R1: values held in reset
      push(cyc + 1, LOW, 0, 1, 0, 0, 0, "R1");
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      c0 = cyc;
      push(c0 + DSTEP - 1, LOW, 0, 1, 0, 0, 0, "R1");
      push(c0 + DSTEP,     LOW, 1, 1, 0, 0, 0, "R1");
      wait_to(c0 + DSTEP + 2);

      // R2 R4 R6: staircase at code 0 with mode request 1
      sel = 1'b1; slew = 3'd0;
      e0 = cyc + 1;
      push(e0, LOW, 0, 0, 1, 0, 0, "R6");
      for (int k = 1; k <= NSTEP; k++) begin
         push(e0 + k * BASE - 1, LOW + CW'(k - 1), 0, 0, 1, 0, 0, "R2");
         push(e0 + k * BASE,     LOW + CW'(k),     0, 0, 1, 0, 0, "R2");
      end
      et = e0 + NSTEP * BASE;
      push(et + DSTEP - 1, HIGH, 0, 0, 1, 0, 0, "R4");
      push(et + DSTEP,     HIGH, 1, 1, 0, 0, 0, "R4");
      wait_to(et + DSTEP + 1);

      // R9: enable follows mode request while idle
      mode = 1'b0;
      push(cyc + 1, HIGH, 1, 0, 0, 0, 0, "R9");
      @(negedge clk);

      // R7: downward move forces pulse skipping despite mode 0
      sel = 1'b0; settled = 1'b0;
      e0 = cyc + 1;
      push(e0,     LOW, 0, 1, 0, 1, 1, "R7");
      push(e0 + 3, LOW, 0, 1, 0, 1, 1, "R7");
      wait_to(e0 + 3);
      settled = 1'b1;
      push(cyc + 1, LOW, 1, 0, 0, 0, 0, "R7");
      @(negedge clk);
      settled = 1'b0;
      @(negedge clk);

      // R2: slower staircase at code 2, interval BASE<<2
      sel = 1'b1; slew = 3'd2;
      e0 = cyc + 1;
      push(e0 + 4 * BASE - 1, LOW,          0, 0, 1, 0, 0, "R2");
      push(e0 + 4 * BASE,     LOW + CW'(1), 0, 0, 1, 0, 0, "R2");
      wait_to(e0 + 4 * BASE + 1);

      // R8: reverse mid-ramp, then reverse again while waiting to settle
      sel = 1'b0;
      e1 = cyc + 1;
      push(e1, LOW, 0, 1, 0, 1, 1, "R8");
      wait_to(e1 + 2);
      sel = 1'b1; slew = 3'd0;
      e2 = cyc + 1;
      push(e2,        LOW,          0, 0, 1, 0, 0, "R8");
      push(e2 + BASE, LOW + CW'(1), 0, 0, 1, 0, 0, "R8");
      et = e2 + NSTEP * BASE;
      push(et + DSTEP - 1, HIGH, 0, 0, 1, 0, 0, "R8");
      push(et + DSTEP,     HIGH, 1, 0, 0, 0, 0, "R8");
      wait_to(et + DSTEP + 1);

      // return low before the single-step case
      sel = 1'b0;
      e1 = cyc + 1;
      wait_to(e1 + 1);
      settled = 1'b1;
      @(negedge clk);
      settled = 1'b0;
      @(negedge clk);

      // R3 R5: single-step move, power-good after settle plus delay
      sel = 1'b1; slew = 3'b111;
      e0 = cyc + 1;
      push(e0, HIGH, 0, 0, 1, 0, 0, "R3");
      push(e0 + 2, HIGH, 0, 0, 1, 0, 0, "R5");
      wait_to(e0 + 2);
      settled = 1'b1;
      push(e0 + 3 + DSET - 1, HIGH, 0, 0, 1, 0, 0, "R5");
      push(e0 + 3 + DSET,     HIGH, 1, 0, 0, 0, 0, "R5");
      wait_to(e0 + 3 + DSET + 1);
      settled = 1'b0;

      // R9: enable back on with mode request 1
      mode = 1'b1;
      push(cyc + 1, HIGH, 1, 1, 0, 0, 0, "R9");

      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule